// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block sits between asynchronous external interrupt pins and a small processor core. Each channel samples its pin on the core clock. A 2-bit sense field picks the condition that counts as an interrupt: a low level, any change, a falling edge or a rising edge. In the three edge-style modes a detected event is held in a pending flag. The flag clears when the core acknowledges that channel or when software writes a one to it. In low-level mode the request follows the sampled pin directly and nothing is stored.

A channel asks for service only when its mask bit and the global interrupt enable are both set. When several channels ask at once, the lowest-numbered one is presented. The core sees a single request line and the index of the winning channel. It accepts the request by pulsing the acknowledge input together with that index.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Channel c takes its mode from `sense_i[2c+1:2c]`. The codes are 00 for a low level, 01 for any change, 10 for a falling edge and 11 for a rising edge.
- R2: Each pin passes through two synchronizer flops and one sample flop, and edges are found only by comparing the two newest synchronized samples. A pin change driven before rising edge k sets the pending flag after edge k+2. In low-level mode, a low pin raises the request after edge k+1.
- R3: In an edge-style mode, a pin pulse that lasts one full clock period sets the pending flag.
- R4: In the edge-style modes, an event sets `pend_o[c]`. The flag stays set until a cycle with `ack_i` high and `ack_id_i == c`, or a cycle with `clr_i[c]` high, and it clears on that edge.
- R5: `req_o` is high exactly when `gie_i` is high and at least one channel with its `mask_i` bit set is active. A channel is active when its pending flag is set, or, in low-level mode, when its sampled pin is low. Changes to the mask and enable inputs act in the same cycle.
- R6: Low-level mode never sets the pending flag. Its request disappears two edges after the pin returns high.
- R7: The pending flag is set even while the channel is masked or `gie_i` is low. The request appears as soon as both enables are set.
- R8: If an event and a clear or acknowledge for the same channel fall in the same cycle, the pending flag stays set.
- R9: Reset (`rst_ni` low) clears the pending flags and loads the synchronizers with a high level, so that releasing reset with the pins high produces no event.
- R10: When several channels are active and enabled, `req_id_o` gives the lowest index. When `req_o` is low, `req_id_o` is 0.
- R11: The channels are independent. Acknowledging or clearing one channel leaves the other channel's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NCH | Asynchronous external interrupt pins |
| sense_i | input | 2*NCH | Sense mode fields, 2 bits per channel |
| mask_i | input | NCH | Per-channel enable |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Core accepts a request |
| ack_id_i | input | IDW | Channel index being accepted |
| clr_i | input | NCH | Write-one-to-clear of the pending flags |
| pend_o | output | NCH | Pending flags |
| req_o | output | 1 | Interrupt request to the core |
| req_id_o | output | IDW | Index of the presented channel |

## Verification
The case that is hardest to reach from the ports is R8, where a new edge and an acknowledge for the same channel meet in one cycle. The edge is visible only inside the synchronizer pipeline. The bench therefore counts edges from the pin change: it drives the pin, waits two clock edges, and asserts the acknowledge during the one cycle in which the event is live. It then checks that the flag survives. Random pin, mode, mask and clear traffic, with one-cycle pulses and back-to-back acknowledges, is compared on every cycle against a behavioural model.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int SENSE_W = 2;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_mode_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic cur_o,
  output logic prev_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {DEPTH{IDLE}};
    else         chain_q <= {chain_q[DEPTH-2:0], pin_i};
  end

  // newest synchronized sample and the one before it
  assign cur_o  = chain_q[STAGES-1];
  assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cur_i,
  input  logic        prev_i,
  input  sense_mode_e mode_i,
  input  logic        ack_i,
  input  logic        clr_i,
  output logic        pend_o,
  output logic        active_o
);
  logic evt;
  logic pend_q;

  always_comb begin
    unique case (mode_i)
      SENSE_ANY:  evt = cur_i ^ prev_i;
      SENSE_FALL: evt = prev_i & ~cur_i;
      SENSE_RISE: evt = ~prev_i & cur_i;
      default:    evt = 1'b0;
    endcase
  end

  // a fresh event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= evt | (pend_q & ~(ack_i | clr_i));
  end

  assign pend_o   = pend_q;
  assign active_o = (mode_i == SENSE_LOW) ? ~cur_i : pend_q;
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb #(
  parameter int NCH = 2,
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] cand_i,
  output logic           any_o,
  output logic [IDW-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (cand_i[c]) id_o = IDW'(c);
    end
  end

  assign any_o = |cand_i;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NCH = 2,
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCH-1:0]       pin_i,
  input  logic [SENSE_W*NCH-1:0] sense_i,
  input  logic [NCH-1:0]       mask_i,
  input  logic                 gie_i,
  input  logic                 ack_i,
  input  logic [IDW-1:0]       ack_id_i,
  input  logic [NCH-1:0]       clr_i,
  output logic [NCH-1:0]       pend_o,
  output logic                 req_o,
  output logic [IDW-1:0]       req_id_o
);
  logic [NCH-1:0] cur, prev, active, cand;
  logic           any;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ext_irq_sync #(.STAGES(2), .IDLE(1'b1)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[c]),
      .cur_o  (cur[c]),
      .prev_o (prev[c])
    );

    ext_irq_detect u_det (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cur_i    (cur[c]),
      .prev_i   (prev[c]),
      .mode_i   (sense_mode_e'(sense_i[SENSE_W*c +: SENSE_W])),
      .ack_i    (ack_i && (ack_id_i == IDW'(c))),
      .clr_i    (clr_i[c]),
      .pend_o   (pend_o[c]),
      .active_o (active[c])
    );

    assign cand[c] = active[c] & mask_i[c] & gie_i;
  end

  ext_irq_arb #(.NCH(NCH)) u_arb (
    .cand_i (cand),
    .any_o  (any),
    .id_o   (req_id_o)
  );

  assign req_o = any;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int NCH = 2,
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NCH-1:0]       pin_i,
  input logic [2*NCH-1:0]     sense_i,
  input logic [NCH-1:0]       mask_i,
  input logic                 gie_i,
  input logic                 ack_i,
  input logic [IDW-1:0]       ack_id_i,
  input logic [NCH-1:0]       clr_i,
  input logic [NCH-1:0]       pend_o,
  input logic                 req_o,
  input logic [IDW-1:0]       req_id_o
);
  logic unused_pin;
  assign unused_pin = ^pin_i;

  assert_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (gie_i && (|mask_i)));

  assert_idle_id_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (req_id_o == '0));

  assert_prio_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && req_id_o != '0) |->
      !(mask_i[0] && pend_o[0] && sense_i[1:0] != 2'b00));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_o[c]) |-> $past((ack_i && ack_id_i == IDW'(c)) || clr_i[c]));

    assert_nolatch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_o[c]) |-> ($past(sense_i[2*c +: 2]) != 2'b00));
  end
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/ext_irq_ctrl_test.sv
`timescale 1ns/1ps
module ext_irq_ctrl_test;
  localparam int NCH = 2;
  localparam int IDW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] pin = '1, mask = '0, clr = '0, pend;
  logic [2*NCH-1:0] sense = '0;
  logic gie = 1'b0, ack = 1'b0, req;
  logic [IDW-1:0] ack_id = '0, req_id;

  int checks = 0, fails = 0;
  bit done = 0;

  ext_irq_ctrl #(.NCH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .sense_i(sense),
    .mask_i(mask), .gie_i(gie), .ack_i(ack), .ack_id_i(ack_id),
    .clr_i(clr), .pend_o(pend), .req_o(req), .req_id_o(req_id)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  int s1[NCH], s2[NCH], s3[NCH], pd[NCH];
  initial for (int c = 0; c < NCH; c++) begin s1[c] = 1; s2[c] = 1; s3[c] = 1; pd[c] = 0; end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin s1[c] = 1; s2[c] = 1; s3[c] = 1; pd[c] = 0; end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int m, ev, kill;
        m = sense[2*c +: 2];
        ev = 0;
        if (m == 1) ev = (s2[c] != s3[c]);
        if (m == 2) ev = (s3[c] == 1 && s2[c] == 0);
        if (m == 3) ev = (s3[c] == 0 && s2[c] == 1);
        kill = (ack && ack_id == c) || clr[c];
        pd[c] = (ev || (pd[c] && !kill)) ? 1 : 0;
        s3[c] = s2[c]; s2[c] = s1[c]; s1[c] = pin[c];
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1.5;
    if (rst_n && !done) begin
      int mreq, mid, found;
      mreq = 0; mid = 0; found = 0;
      for (int c = 0; c < NCH; c++) begin
        int act;
        act = (sense[2*c +: 2] == 0) ? (s2[c] == 0) : pd[c];
        if (act && mask[c] && gie && !found) begin mreq = 1; mid = c; found = 1; end
      end
      for (int c = 0; c < NCH; c++) chk("R4 model pend", pend[c], pd[c]);
      chk("R5 model req", req, mreq);
      chk("R10 model req_id", req_id, mid);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; #1;
    chk("R9 reset pend", pend, 0);
    chk("R9 reset req", req, 0);
    cyc(3); #1;
    chk("R9 no false edge", pend, 0);

    // level mode, ch0
    mask = 2'b01; gie = 1'b1; sense = 4'b0000;
    cyc(1); pin[0] = 1'b0;
    cyc(1); #1 chk("R2 level after 1 edge", req, 0);
    cyc(1); #1 chk("R6 level request", req, 1);
    pin[0] = 1'b1;
    cyc(3); #1;
    chk("R6 level not latched req", req, 0);
    chk("R6 level not latched pend", pend[0], 0);

    // falling edge, ch0
    sense = 4'b0010;
    cyc(1); pin[0] = 1'b0;
    cyc(2); #1 chk("R2 fall after 2 edges", pend[0], 0);
    cyc(1); #1 chk("R1 fall sets pend", pend[0], 1);
    chk("R5 request", req, 1);
    cyc(1); ack = 1'b1; ack_id = 1'b0;
    cyc(1); ack = 1'b0; #1 chk("R4 ack clears", pend[0], 0);

    // rising while masked
    mask = 2'b00; sense = 4'b0011; pin[0] = 1'b1;
    cyc(4); #1;
    chk("R7 pend while masked", pend[0], 1);
    chk("R7 no req while masked", req, 0);
    mask = 2'b01; #0.1 chk("R7 req on unmask", req, 1);
    cyc(1); gie = 1'b0; #0.1 chk("R5 gie gates", req, 0);
    cyc(1); gie = 1'b1; clr = 2'b01;
    cyc(1); clr = 2'b00; #1 chk("R4 clr clears", pend[0], 0);

    // one-cycle pulse on ch1, rising
    sense = 4'b1111; pin[1] = 1'b0;
    cyc(4); clr = 2'b10;
    cyc(1); clr = 2'b00; pin[1] = 1'b1;
    cyc(1); pin[1] = 1'b0;
    cyc(4); #1 chk("R3 short pulse", pend[1], 1);

    // priority
    mask = 2'b11; pin[0] = 1'b0;
    cyc(4); pin[0] = 1'b1;
    cyc(4); #1;
    chk("R10 ch0 first", req_id, 0);
    ack = 1'b1; ack_id = 1'b0;
    cyc(1); ack = 1'b0; #1;
    chk("R11 ch0 cleared", pend[0], 0);
    chk("R11 ch1 kept", pend[1], 1);
    chk("R10 ch1 next", req_id, 1);

    // event + ack collision on ch1 (pend1 already set)
    cyc(4); pin[1] = 1'b1;
    cyc(2); ack = 1'b1; ack_id = 1'b1;
    cyc(1); ack = 1'b0; #1 chk("R8 event beats ack", pend[1], 1);

    // any change, ch0
    sense = 4'b1101; clr = 2'b11;
    cyc(1); clr = 2'b00; pin[0] = 1'b0;
    cyc(4); #1 chk("R1 any change", pend[0], 1);

    // random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      cyc(1);
      ack = 1'b0; clr = '0;
      if ($urandom_range(3) == 0) pin[$urandom_range(NCH-1)] ^= 1'b1;
      if ($urandom_range(63) == 0) sense = 4'($urandom);
      if ($urandom_range(31) == 0) mask = 2'($urandom);
      if ($urandom_range(31) == 0) gie = ~gie;
      if ($urandom_range(15) == 0) clr = 2'($urandom);
      if (req && $urandom_range(1) == 0) begin ack = 1'b1; ack_id = req_id; end
      else if ($urandom_range(15) == 0) begin ack = 1'b1; ack_id = 1'($urandom); end
    end
    cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule